// File: doc/BRIEF.md
# Clock Controller Register File with Peripheral-Clock Frequency Query

This block is the register bank of a clock controller together with a small engine that works out, in hertz, the frequency of the peripheral bus clock those registers configure. Software reaches the bank over a 32-bit register bus with valid/ready handshake, spread across a 4 KB window. Each register has its own write mask. One register always has a fixed bit set on every write. The remaining registers are read-only and keep their reset values.

Other logic on the chip asks for a clock frequency through the query port and gets back a Hz value. The engine first chooses a reference: a fixed 26 MHz crystal, or a 32768 Hz low-frequency source that may be multiplied by 1024. It then chooses between that reference and the main PLL output, which arrives as an input value. It then applies two cascaded divide-by-(field+1) stages. Both divisions run on one shared shift-subtract divider. A state machine sequences the divider through the states IDLE, BUS_DIV, PERIPH_DIV and REPORT. Its transitions are:
- IDLE to BUS_DIV when a query for a divided clock is accepted.
- IDLE to REPORT when a query for a constant-answer clock is accepted.
- BUS_DIV to PERIPH_DIV when the first division completes.
- PERIPH_DIV to REPORT when the second division completes.
- REPORT to IDLE unconditionally.

Top module: `clkctl_regfile`

## Requirements
- R1: The block accepts a request on every cycle. The register index is `req_addr[11:2]`. Exactly one cycle after an accepted request, `rsp_valid` is high. For an aligned read whose index is below 26, `rsp_rdata` then holds the stored word; this includes read-only registers.
- R2: The following return `rsp_rdata` = 0 and raise `rsp_err` for that single response cycle: a read from index 26 or above, and any access whose `req_addr[1:0]` is not zero. A misaligned write changes no register.
- R3: A write to the control register (index 0) stores `(wdata & 0x3B6FDFFF) | 0x04000000`. Bit 26 therefore always reads back as 1.
- R4: A write to divider register 0 (index 4) is masked with 0xFF9F3FFF. Writes to the main PLL register (index 1) and the secondary PLL register (index 2) are each masked with 0xBFFF3FFF.
- R5: Divider register 1 (index 5) and the three gating registers (indices 7, 8, 9) store all 32 bits. A write to any other index changes nothing and raises `rsp_err`.
- R6: Reset values by index are as follows:
  - 0: 0x074B0B7D
  - 1: 0x04001800
  - 2: 0x04043001
  - 3: 0x04051C03
  - 4: 0xFF870B48
  - 5: 0x49FCFE7F
  - 6: 0x00000285
  - 7, 8, 9 and 10: 0xFFFFFFFF
  - 11: 0x007F0000
  - 12: 0x00000280
  - 13: 0x80209828
  - 14: 0x00AA0000
  - 16: 0x00004040
  - every other index: 0
- R7: The reference depends on the control field `ctrl[2:1]`. If that field equals 2, the reference is 32768 Hz when `ctrl[8]` is set, multiplied by 1024 when `ctrl[26]` is set; it is 0 when `ctrl[8]` is clear. For any other value of the field, the reference is 26 000 000 Hz.
- R8: The main clock is the reference when `ctrl[7]` (bypass) is set or `ctrl[3]` (PLL enable) is clear. Otherwise it is `pll_hz`.
- R9: The peripheral frequency is computed in two integer divisions, each truncating. First, bus = main / (`div0[2:0]` + 1). Then the result = bus / (`div0[7:6]` + 1).
- R10: The query identifiers are:
  - 0: returns 0.
  - 1 and 2: return the R9 value.
  - 3: returns 32768.
  - 4 to 7: return 0, with `q_unsup` high in the result cycle.
- R11: A query is accepted only while `q_busy` is low. From the next cycle `q_busy` is high, up to and including the cycle in which `q_done` pulses for exactly one cycle. `q_hz` holds the result after that.
- R12: Register writes made while a query is busy do not change the result of that query. The result reflects the register contents and the `pll_hz` value at the moment the query was accepted.
- R13: `err_sticky` is 0 after reset. It is set in the same cycle as any `rsp_err`, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the 4 KB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle, one after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error for this response |
| err_sticky | output | 1 | Latched access error |
| pll_hz | input | 32 | Main PLL output frequency in Hz |
| q_valid | input | 1 | Frequency query request |
| q_clk_id | input | 3 | Clock identifier to query |
| q_busy | output | 1 | Query in progress |
| q_done | output | 1 | One-cycle result strobe |
| q_hz | output | 32 | Result frequency in Hz |
| q_unsup | output | 1 | Unsupported identifier, valid with q_done |

## Verification
A corrupted register shows up the next time that index is read. It also shows up in the next frequency result, since both dividers and the source selection come from stored words. A wrong divider step or a stale snapshot produces a wrong `q_hz` at the `q_done` of the query that used it, about 70 cycles after acceptance. A state-machine fault appears as a `q_done` that arrives late, never arrives, or lasts more than one cycle. The sweep covers every combination of source select, bypass, PLL enable, pre-multiplier enable and both divider fields, so any of these faults changes at least one checked result.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int WORD_W       = 32;
    localparam int REG_COUNT    = 26;
    localparam int XTAL_HZ      = 26_000_000;
    localparam int LOWF_HZ      = 32_768;
    localparam int LOWF_MULT_SH = 10;

    // register indices (byte offset >> 2)
    localparam int IX_CTRL  = 0;
    localparam int IX_MPLL  = 1;
    localparam int IX_SPLL  = 2;
    localparam int IX_UPLL  = 3;
    localparam int IX_DIV0  = 4;
    localparam int IX_DIV1  = 5;
    localparam int IX_DIV2  = 6;
    localparam int IX_GATE0 = 7;
    localparam int IX_GATE1 = 8;
    localparam int IX_GATE2 = 9;
    localparam int IX_WAKE  = 10;
    localparam int IX_RSTAT = 11;
    localparam int IX_COUT  = 12;
    localparam int IX_PWR0  = 13;
    localparam int IX_PWR1  = 14;
    localparam int IX_TRK1  = 16;

    // control-word field positions
    localparam int CB_SRC_LO  = 1;
    localparam int CB_PLL_EN  = 3;
    localparam int CB_BYPASS  = 7;
    localparam int CB_PRE_EN  = 8;
    localparam int CB_MULT    = 26;
    localparam int SRC_LOWF   = 2;

    // divider-0 field positions
    localparam int DB_BUS_LO  = 0;
    localparam int DB_BUS_W   = 3;
    localparam int DB_PER_LO  = 6;
    localparam int DB_PER_W   = 2;

    typedef enum logic [2:0] {
        CID_NONE   = 3'd0,
        CID_PERIPH = 3'd1,
        CID_PERHI  = 3'd2,
        CID_SLOW   = 3'd3
    } clk_id_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_BUS_DIV    = 2'd1,
        ST_PERIPH_DIV = 2'd2,
        ST_REPORT     = 2'd3
    } qstate_e;

    function automatic logic [WORD_W-1:0] reg_reset(input int idx);
        case (idx)
            IX_CTRL:  return 32'h074B_0B7D;
            IX_MPLL:  return 32'h0400_1800;
            IX_SPLL:  return 32'h0404_3001;
            IX_UPLL:  return 32'h0405_1C03;
            IX_DIV0:  return 32'hFF87_0B48;
            IX_DIV1:  return 32'h49FC_FE7F;
            IX_DIV2:  return 32'h0000_0285;
            IX_GATE0, IX_GATE1, IX_GATE2, IX_WAKE: return 32'hFFFF_FFFF;
            IX_RSTAT: return 32'h007F_0000;
            IX_COUT:  return 32'h0000_0280;
            IX_PWR0:  return 32'h8020_9828;
            IX_PWR1:  return 32'h00AA_0000;
            IX_TRK1:  return 32'h0000_4040;
            default:  return '0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] write_mask(input int idx);
        case (idx)
            IX_CTRL:          return 32'h3B6F_DFFF;
            IX_MPLL, IX_SPLL: return 32'hBFFF_3FFF;
            IX_DIV0:          return 32'hFF9F_3FFF;
            IX_DIV1, IX_GATE0, IX_GATE1, IX_GATE2: return 32'hFFFF_FFFF;
            default:          return '0;
        endcase
    endfunction

    function automatic logic reg_writable(input int idx);
        case (idx)
            IX_CTRL, IX_MPLL, IX_SPLL, IX_DIV0, IX_DIV1,
            IX_GATE0, IX_GATE1, IX_GATE2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] force_bits(input int idx);
        return (idx == IX_CTRL) ? (32'h1 << CB_MULT) : '0;
    endfunction

endpackage

// File: rtl/clkctl_bank.sv
module clkctl_bank
    import clkctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = REG_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              err_sticky,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] div0_word
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              aligned, in_range, can_write, wr_en, bad;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] regs [NUM_REGS];

    assign idx       = req_addr[ADDR_W-1:2];
    assign aligned   = (req_addr[1:0] == 2'b00);
    assign in_range  = (int'(idx) < NUM_REGS);
    assign can_write = reg_writable(int'(idx));
    assign wr_en     = req_valid && req_write && aligned && in_range && can_write;
    assign bad       = !aligned || !in_range || (req_write && !can_write);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [WORD_W-1:0] q;
        if (reg_writable(g)) begin : g_rw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= reg_reset(g);
                else if (wr_en && (idx == IDX_W'(g)))
                    q <= (req_wdata & write_mask(g)) | force_bits(g);
            end
        end else begin : g_ro
            assign q = reg_reset(g);
        end
        assign regs[g] = q;
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) rd_word = regs[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            rsp_err    <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_err    <= req_valid && bad;
            err_sticky <= err_sticky || (req_valid && bad);
            rsp_rdata  <= (req_valid && !req_write && aligned && in_range) ? rd_word : '0;
        end
    end

    assign ctrl_word = regs[IX_CTRL];
    assign div0_word = regs[IX_DIV0];
endmodule

// File: rtl/clkctl_divider.sv
module clkctl_divider #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] dividend,
    input  logic [DEN_W-1:0] divisor,
    output logic             done,
    output logic [NUM_W-1:0] quotient
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [CNT_W-1:0] cnt;
    logic [DEN_W-1:0] rem, den, nrem;
    logic [DEN_W:0]   trial;
    logic             qbit;

    always_comb begin
        trial = {rem, quotient[NUM_W-1]};
        if (trial >= {1'b0, den}) begin
            qbit = 1'b1;
            nrem = DEN_W'(trial - {1'b0, den});
        end else begin
            qbit = 1'b0;
            nrem = trial[DEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rem      <= '0;
            den      <= '0;
            quotient <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                quotient <= dividend;
                rem      <= '0;
                den      <= divisor;
                cnt      <= CNT_W'(NUM_W);
            end else if (cnt != '0) begin
                rem      <= nrem;
                quotient <= {quotient[NUM_W-2:0], qbit};
                cnt      <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/clkctl_freq_fsm.sv
module clkctl_freq_fsm
    import clkctl_pkg::*;
#(
    parameter int HZ_W  = 32,
    parameter int DEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [2:0]        q_clk_id,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] div0_word,
    input  logic [HZ_W-1:0]   pll_hz,
    output logic              q_busy,
    output logic              q_done,
    output logic [HZ_W-1:0]   q_hz,
    output logic              q_unsup,
    output logic              div_start,
    output logic [HZ_W-1:0]   div_dividend,
    output logic [DEN_W-1:0]  div_divisor,
    input  logic              div_done,
    input  logic [HZ_W-1:0]   div_quot
);
    qstate_e          state, state_nx;
    logic [HZ_W-1:0]  ref_hz, main_hz, hz_q;
    logic [DEN_W-1:0] bus_den, per_den, per_den_q;
    logic             unsup_q, accept, needs_div;

    always_comb begin
        if (ctrl_word[CB_SRC_LO +: 2] == 2'(SRC_LOWF)) begin
            if (!ctrl_word[CB_PRE_EN])   ref_hz = '0;
            else if (ctrl_word[CB_MULT]) ref_hz = HZ_W'(LOWF_HZ) << LOWF_MULT_SH;
            else                         ref_hz = HZ_W'(LOWF_HZ);
        end else begin
            ref_hz = HZ_W'(XTAL_HZ);
        end
        main_hz = (ctrl_word[CB_BYPASS] || !ctrl_word[CB_PLL_EN]) ? ref_hz : pll_hz;
        bus_den = DEN_W'(div0_word[DB_BUS_LO +: DB_BUS_W]) + 1'b1;
        per_den = DEN_W'(div0_word[DB_PER_LO +: DB_PER_W]) + 1'b1;
    end

    assign accept    = (state == ST_IDLE) && q_valid;
    assign needs_div = (q_clk_id == CID_PERIPH) || (q_clk_id == CID_PERHI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (accept) state_nx = needs_div ? ST_BUS_DIV : ST_REPORT;
            ST_BUS_DIV:    if (div_done) state_nx = ST_PERIPH_DIV;
            ST_PERIPH_DIV: if (div_done) state_nx = ST_REPORT;
            ST_REPORT:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        div_start    = 1'b0;
        div_dividend = main_hz;
        div_divisor  = bus_den;
        unique case (state)
            ST_IDLE:    div_start = accept && needs_div;
            ST_BUS_DIV: begin
                div_start    = div_done;
                div_dividend = div_quot;
                div_divisor  = per_den_q;
            end
            ST_PERIPH_DIV, ST_REPORT: ;
        endcase
        q_busy  = (state != ST_IDLE);
        q_done  = (state == ST_REPORT);
        q_unsup = (state == ST_REPORT) && unsup_q;
        q_hz    = hz_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hz_q      <= '0;
            unsup_q   <= 1'b0;
            per_den_q <= '0;
        end else if (accept) begin
            per_den_q <= per_den;
            unsup_q   <= (q_clk_id > CID_SLOW);
            hz_q      <= (q_clk_id == CID_SLOW) ? HZ_W'(LOWF_HZ) : '0;
        end else if (state == ST_PERIPH_DIV && div_done) begin
            hz_q <= div_quot;
        end
    end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = REG_COUNT,
    parameter int HZ_W     = 32,
    parameter int DEN_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              err_sticky,
    input  logic [HZ_W-1:0]   pll_hz,
    input  logic              q_valid,
    input  logic [2:0]        q_clk_id,
    output logic              q_busy,
    output logic              q_done,
    output logic [HZ_W-1:0]   q_hz,
    output logic              q_unsup
);
    logic [WORD_W-1:0] ctrl_word, div0_word;
    logic              div_start, div_done;
    logic [HZ_W-1:0]   div_dividend, div_quot;
    logic [DEN_W-1:0]  div_divisor;

    assign req_ready = 1'b1;

    clkctl_bank #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .err_sticky(err_sticky),
        .ctrl_word(ctrl_word), .div0_word(div0_word)
    );

    clkctl_freq_fsm #(.HZ_W(HZ_W), .DEN_W(DEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .q_valid(q_valid), .q_clk_id(q_clk_id),
        .ctrl_word(ctrl_word), .div0_word(div0_word), .pll_hz(pll_hz),
        .q_busy(q_busy), .q_done(q_done), .q_hz(q_hz), .q_unsup(q_unsup),
        .div_start(div_start), .div_dividend(div_dividend),
        .div_divisor(div_divisor), .div_done(div_done), .div_quot(div_quot)
    );

    clkctl_divider #(.NUM_W(HZ_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n),
        .start(div_start), .dividend(div_dividend), .divisor(div_divisor),
        .done(div_done), .quotient(div_quot)
    );
endmodule

// File: rtl/clkctl_regfile_checker.sv
module clkctl_regfile_checker #(
    parameter int ADDR_W = 12,
    parameter int HZ_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic              err_sticky,
    input logic [HZ_W-1:0]   pll_hz,
    input logic              q_valid,
    input logic [2:0]        q_clk_id,
    input logic              q_busy,
    input logic              q_done,
    input logic [HZ_W-1:0]   q_hz,
    input logic              q_unsup
);
    p_err_in_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_ctrl_bit_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == '0) |=> rsp_rdata[26]);

    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q_done |=> !q_done);

    p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_busy) |=> q_busy);

    p_done_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        q_done |-> q_busy);

    p_unsup_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q_unsup |-> (q_done && q_hz == '0));

    p_sticky_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> err_sticky);

    p_sticky_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);
endmodule

bind clkctl_regfile clkctl_regfile_checker #(.ADDR_W(ADDR_W), .HZ_W(HZ_W)) u_chk (.*);

// File: tb/clkctl_regfile_bench.sv
`timescale 1ns/1ps
module clkctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err, err_sticky;
    logic [31:0] rsp_rdata;
    logic [31:0] pll_hz = 32'd399_000_000;
    logic        q_valid = 1'b0;
    logic [2:0]  q_clk_id = '0;
    logic        q_busy, q_done, q_unsup;
    logic [31:0] q_hz;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    clkctl_regfile u_clkctl_regfile (.*);

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_reset(input int i);
        case (i)
            0: return 32'h074B0B7D;  1: return 32'h04001800;
            2: return 32'h04043001;  3: return 32'h04051C03;
            4: return 32'hFF870B48;  5: return 32'h49FCFE7F;
            6: return 32'h00000285;  7, 8, 9, 10: return 32'hFFFFFFFF;
            11: return 32'h007F0000; 12: return 32'h00000280;
            13: return 32'h80209828; 14: return 32'h00AA0000;
            16: return 32'h00004040; default: return 32'h0;
        endcase
    endfunction

    function automatic bit m_wr(input int i);
        return (i == 0 || i == 1 || i == 2 || i == 4 || i == 5 || i == 7 || i == 8 || i == 9);
    endfunction

    function automatic logic [31:0] m_store(input int i, input logic [31:0] w);
        case (i)
            0: return (w & 32'h3B6FDFFF) | 32'h04000000;
            1, 2: return w & 32'hBFFF3FFF;
            4: return w & 32'hFF9F3FFF;
            default: return w;
        endcase
    endfunction

    function automatic logic [31:0] m_ipg(input logic [31:0] c, input logic [31:0] d,
                                          input logic [31:0] p);
        logic [31:0] r, mn;
        if (c[2:1] == 2'd2) r = !c[8] ? 32'd0 : (c[26] ? 32'd32768 * 32'd1024 : 32'd32768);
        else r = 32'd26_000_000;
        mn = (c[7] || !c[3]) ? r : p;
        return (mn / (32'(d[2:0]) + 1)) / (32'(d[7:6]) + 1);
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] w, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = w;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        e = rsp_err;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata; e = rsp_err;
        n_chk++;
        if (rsp_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R1 rsp_valid actual=%b expected=1", rsp_valid);
        end
    endtask

    task automatic wait_done(output logic [31:0] hz, output logic un);
        int n = 0;
        while (!q_done && n < 300) begin @(negedge clk); n++; end
        check("R11", "done seen", {31'd0, q_done}, 32'd1);
        hz = q_hz; un = q_unsup;
        @(negedge clk);
        check("R11", "done one cycle", {31'd0, q_done}, 32'd0);
        check("R11", "hz held", q_hz, hz);
    endtask

    task automatic query(input logic [2:0] id, output logic [31:0] hz, output logic un);
        @(negedge clk);
        q_valid = 1'b1; q_clk_id = id;
        @(negedge clk);
        q_valid = 1'b0;
        check("R11", "busy after accept", {31'd0, q_busy}, 32'd1);
        wait_done(hz, un);
    endtask

    initial begin : wdog
        repeat (190_000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, hz, c_st, d_st, exp;
        logic e, un;
        repeat (3) @(negedge clk);
        check("R13", "sticky in reset", {31'd0, err_sticky}, 32'd0);
        check("R11", "busy in reset", {31'd0, q_busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset values, and R1 read path
        for (int i = 0; i < 26; i++) begin
            bus_read(12'(i * 4), d, e);
            check("R6", $sformatf("reset idx %0d", i), d, m_reset(i));
            check("R1", "no err on read", {31'd0, e}, 32'd0);
        end
        check("R13", "sticky clear", {31'd0, err_sticky}, 32'd0);

        // R10/R11 query after reset: reset ctrl uses PLL, div0 bus /1, periph /2
        query(3'd1, hz, un);
        check("R9", "reset periph hz", hz, m_ipg(m_reset(0), m_reset(4), pll_hz));

        // R2: out of range and misaligned
        bus_read(12'd104, d, e);
        check("R2", "oor data", d, 32'd0);
        check("R2", "oor err", {31'd0, e}, 32'd1);
        check("R13", "sticky set", {31'd0, err_sticky}, 32'd1);
        bus_read(12'hFFC, d, e);
        check("R2", "top data", d, 32'd0);
        check("R2", "top err", {31'd0, e}, 32'd1);
        bus_read(12'h001, d, e);
        check("R2", "misaligned read data", d, 32'd0);
        check("R2", "misaligned read err", {31'd0, e}, 32'd1);
        bus_write(12'h016, 32'h0, e);
        check("R2", "misaligned write err", {31'd0, e}, 32'd1);
        bus_read(12'h014, d, e);
        check("R2", "misaligned write no effect", d, m_reset(5));
        bus_write(12'd200, 32'h0, e);
        check("R5", "oor write err", {31'd0, e}, 32'd1);

        // R3 R4 R5: write sweep over every index with two patterns
        for (int i = 0; i < 26; i++) begin
            for (int k = 0; k < 2; k++) begin
                logic [31:0] w;
                w = (k == 0) ? 32'hFFFFFFFF : 32'h00000000;
                bus_write(12'(i * 4), w, e);
                check(i == 0 ? "R3" : (m_wr(i) ? "R4" : "R5"),
                      $sformatf("write err idx %0d", i), {31'd0, e}, {31'd0, !m_wr(i)});
                bus_read(12'(i * 4), d, e);
                exp = m_wr(i) ? m_store(i, w) : m_reset(i);
                check(i == 0 ? "R3" : (m_wr(i) ? "R4" : "R5"),
                      $sformatf("readback idx %0d pat %0d", i, k), d, exp);
            end
        end
        check("R13", "sticky persists", {31'd0, err_sticky}, 32'd1);

        // R7 R8 R9: sweep source, enables and both divider fields
        for (int cmb = 0; cmb < 32; cmb++) begin
            logic [31:0] cw;
            cw = 32'(cmb[1:0]) << 1 | 32'(cmb[2]) << 3 | 32'(cmb[3]) << 7 | 32'(cmb[4]) << 8;
            pll_hz = 32'd400_000_000 - 32'(cmb) * 32'd12345;
            bus_write(12'h000, cw, e);
            c_st = m_store(0, cw);
            for (int mx = 0; mx < 8; mx++) begin
                for (int ip = 0; ip < 4; ip++) begin
                    logic [31:0] dw;
                    dw = 32'h00A1_0000 | 32'(ip) << 6 | 32'(mx);
                    bus_write(12'h010, dw, e);
                    query(3'(1 + (ip & 1)), hz, un);
                    check(cmb[1:0] == 2'd2 ? "R7" : "R8",
                          $sformatf("hz c%0d m%0d i%0d", cmb, mx, ip),
                          hz, m_ipg(c_st, m_store(4, dw), pll_hz));
                    if (mx == 7 && ip == 3)
                        check("R9", "max dividers", hz, m_ipg(c_st, m_store(4, dw), pll_hz));
                end
            end
        end

        // R10: every clock identifier
        for (int id = 0; id < 8; id++) begin
            query(3'(id), hz, un);
            if (id == 1 || id == 2) exp = m_ipg(c_st, d_st, pll_hz);
            else exp = (id == 3) ? 32'd32768 : 32'd0;
            if (id == 1 || id == 2) check("R10", "periph id hz", hz, m_ipg(m_store(0, 32'h198), m_store(4, 32'h00A100C7), pll_hz));
            else check("R10", $sformatf("id %0d hz", id), hz, exp);
            check("R10", $sformatf("id %0d unsup", id), {31'd0, un}, {31'd0, id >= 4});
        end

        // R12: writes during a busy query do not alter its result
        bus_write(12'h000, 32'h0000_0008, e);
        bus_write(12'h010, 32'h0000_0043, e);
        c_st = m_store(0, 32'h8); d_st = m_store(4, 32'h43);
        exp = m_ipg(c_st, d_st, pll_hz);
        @(negedge clk);
        q_valid = 1'b1; q_clk_id = 3'd1;
        @(negedge clk);
        q_valid = 1'b0;
        bus_write(12'h000, 32'h0000_0080, e);
        bus_write(12'h010, 32'h0000_0000, e);
        pll_hz = 32'd1000;
        wait_done(hz, un);
        check("R12", "snapshot result", hz, exp);
        // R11: query presented while busy is ignored
        @(negedge clk);
        q_valid = 1'b1; q_clk_id = 3'd1;
        @(negedge clk);
        q_clk_id = 3'd3;
        @(negedge clk);
        q_valid = 1'b0;
        wait_done(hz, un);
        check("R11", "busy query ignored", hz, m_ipg(m_store(0, 32'h80), 32'h0, 32'd1000));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule